// File: doc/BRIEF.md
# Receive Byte Queue with Idle-Timeout Interrupt

This block sits between the receive shift register of a serial port and the CPU. Each byte the shift register finishes is written into a sixteen-entry first-in first-out store. The CPU takes bytes from the head. The block produces two interrupt requests. The data-ready request is raised once the number of stored bytes reaches a threshold chosen by software. The idle request is raised when bytes have been left unread and nothing has moved in or out for four character periods. The idle request covers the case where a message ends with fewer bytes than the threshold.

A byte that arrives while all sixteen entries are occupied is thrown away and latches a sticky overrun flag. The CPU clears the flag by reading status. The character period is not derived inside the block. A one-cycle strobe per character time comes in from the baud logic.

Top module: `rx_byte_queue`

## Requirements
- R1: The queue holds up to 16 bytes in arrival order. `level` gives the number stored. `rdData` shows the oldest stored byte whenever `level` is non-zero. Each cycle with `rdEn` high and `level` non-zero removes that byte.
- R2: `trigSel` encodes the threshold as 0 = 1 byte, 1 = 4 bytes, 2 = 8 bytes and 3 = 14 bytes. `dataAvailIrq` is high exactly while `rxIntEn` is high and `level` is at or above the threshold. It drops as soon as `level` falls below the threshold.
- R3: A `rxValid` byte that arrives while `level` is 16 is not stored, even if `rdEn` is high in the same cycle. Stored contents and order are unchanged apart from that read.
- R4: A discarded byte sets `overrun` from the next cycle on. `overrun` stays high until a cycle with `statusRd` high, after which it reads low. If a discard and `statusRd` fall in the same cycle, `overrun` stays set.
- R5: While `level` is non-zero, each `charTick` cycle with no accepted write and no accepted read advances an idle count, which saturates at 4. `timeoutIrq` is high while the count is 4, `level` is non-zero and `rxIntEn` is high.
- R6: An accepted write or an accepted read resets the idle count to 0 and lowers `timeoutIrq` from the next cycle. A discarded byte does not reset the count.
- R7: While `level` is 0, the idle count is held at 0 and `timeoutIrq` is low. `rdEn` with `level` 0 leaves `level` at 0.
- R8: With `rxIntEn` low, both interrupt outputs are low. Queue contents and the idle count keep evolving, so raising `rxIntEn` again shows the current conditions at once.
- R9: While `rstN` is low, the queue empties and `overrun` and both interrupts read low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxValid | input | 1 | Shift register has a finished byte this cycle |
| rxData | input | 8 | Byte from the shift register |
| rdEn | input | 1 | CPU read of the queue head |
| rdData | output | 8 | Oldest stored byte |
| statusRd | input | 1 | CPU status read; clears overrun |
| trigSel | input | 2 | Threshold code for the data-ready request |
| rxIntEn | input | 1 | Receive interrupt enable |
| charTick | input | 1 | One-cycle strobe per character time |
| level | output | 5 | Number of stored bytes |
| overrun | output | 1 | Sticky overrun flag |
| dataAvailIrq | output | 1 | Threshold-reached interrupt request |
| timeoutIrq | output | 1 | Idle-timeout interrupt request |

## Verification
The hardest state to reach is an idle count that has already saturated while the queue is completely full. In that state, a discarded byte has to leave the count alone, while an accepted byte in the same situation would restart it. The stimulus gets there by filling all sixteen entries, issuing four character strobes with gaps of idle cycles between them, and then offering one more byte. The bench then expects `timeoutIrq` to stay high while `overrun` rises. The masked-enable case is reached the same way: the count saturates with `rxIntEn` low, and the request must appear on the very cycle the enable returns.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic push;      // store rxData at tail
    logic pop;       // retire head entry
  } rxqCtl_t;

  // threshold code -> byte count
  function automatic int trigBytes(input logic [1:0] sel);
    case (sel)
      2'd0:    trigBytes = 1;
      2'd1:    trigBytes = 4;
      2'd2:    trigBytes = 8;
      default: trigBytes = 14;
    endcase
  endfunction

endpackage

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxqCtl_t           ctl,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] headData,
  output logic [CNT_W-1:0]  fillCount
);

  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [DATA_W-1:0] slotData [DEPTH];

  function automatic logic [PTR_W-1:0] nextIdx(input logic [PTR_W-1:0] idx);
    nextIdx = (idx == LAST_IDX) ? '0 : idx + 1'b1;
  endfunction

  // one register bank per entry, written when the tail points at it
  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotData[g] <= '0;
      end else if (ctl.push && (wrPtr == PTR_W'(g))) begin
        slotData[g] <= wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (ctl.push) wrPtr <= nextIdx(wrPtr);
      if (ctl.pop)  rdPtr <= nextIdx(rdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCount <= '0;
    end else begin
      case ({ctl.push, ctl.pop})
        2'b10:   fillCount <= fillCount + 1'b1;
        2'b01:   fillCount <= fillCount - 1'b1;
        default: fillCount <= fillCount;
      endcase
    end
  end

  assign headData = slotData[rdPtr];

endmodule

// File: rtl/rxq_control.sv
module rxq_control
  import rxq_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int TO_CHARS  = 4,
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int TO_W     = $clog2(TO_CHARS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxValid,
  input  logic             rdEn,
  input  logic             statusRd,
  input  logic             charTick,
  input  logic             rxIntEn,
  input  logic [1:0]       trigSel,
  input  logic [CNT_W-1:0] fillCount,
  output rxqCtl_t          ctl,
  output logic             overrunFlag,
  output logic             dataAvailReq,
  output logic             idleReq
);

  localparam logic [TO_W-1:0] TO_LIMIT = TO_W'(TO_CHARS);

  logic isFull, isEmpty, dropByte, idleRestart, idleAdvance, idleExpired;
  logic [TO_W-1:0] idleCnt;

  assign isFull  = (fillCount == CNT_W'(DEPTH));
  assign isEmpty = (fillCount == '0);

  // strobes to the datapath
  assign ctl.push = rxValid && !isFull;
  assign ctl.pop  = rdEn && !isEmpty;
  assign dropByte = rxValid && isFull;

  // overrun: set dominates clear
  always_ff @(posedge clk) begin
    if (!rstN)         overrunFlag <= 1'b0;
    else if (dropByte) overrunFlag <= 1'b1;
    else if (statusRd) overrunFlag <= 1'b0;
  end

  // idle timer counts character strobes between queue accesses
  assign idleExpired = (idleCnt == TO_LIMIT);
  assign idleRestart = ctl.push || ctl.pop || isEmpty;
  assign idleAdvance = charTick && !idleRestart && !idleExpired;

  always_ff @(posedge clk) begin
    if (!rstN)            idleCnt <= '0;
    else if (idleRestart) idleCnt <= '0;
    else if (idleAdvance) idleCnt <= idleCnt + 1'b1;
  end

  // interrupt requests
  assign dataAvailReq = rxIntEn && (int'(fillCount) >= trigBytes(trigSel));
  assign idleReq      = rxIntEn && idleExpired && !isEmpty;

endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue
  import rxq_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int DEPTH    = 16,
  parameter int TO_CHARS = 4,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  input  logic              statusRd,
  input  logic [1:0]        trigSel,
  input  logic              rxIntEn,
  input  logic              charTick,
  output logic [CNT_W-1:0]  level,
  output logic              overrun,
  output logic              dataAvailIrq,
  output logic              timeoutIrq
);

  rxqCtl_t ctlBus;

  rxq_control #(.DEPTH(DEPTH), .TO_CHARS(TO_CHARS)) u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .rxValid      (rxValid),
    .rdEn         (rdEn),
    .statusRd     (statusRd),
    .charTick     (charTick),
    .rxIntEn      (rxIntEn),
    .trigSel      (trigSel),
    .fillCount    (level),
    .ctl          (ctlBus),
    .overrunFlag  (overrun),
    .dataAvailReq (dataAvailIrq),
    .idleReq      (timeoutIrq)
  );

  rxq_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctlBus),
    .wrData    (rxData),
    .headData  (rdData),
    .fillCount (level)
  );

endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             rxValid,
  input logic             rdEn,
  input logic             statusRd,
  input logic             rxIntEn,
  input logic [CNT_W-1:0] level,
  input logic             overrun,
  input logic             dataAvailIrq,
  input logic             timeoutIrq
);

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    int'(level) <= DEPTH); // R1

  AST_WRITE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rdEn && int'(level) < DEPTH) |=> (level == $past(level) + 1'b1)); // R1

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && !rdEn && int'(level) == DEPTH) |=> (int'(level) == DEPTH)); // R3

  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && int'(level) == DEPTH) |=> overrun); // R4

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !statusRd) |=> overrun); // R4

  AST_ACCESS_CLEARS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ((rdEn && level != '0) || (rxValid && int'(level) < DEPTH)) |=> !timeoutIrq); // R6

  AST_EMPTY_NO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (level == '0) |-> !timeoutIrq); // R7

  AST_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    !rxIntEn |-> (!dataAvailIrq && !timeoutIrq)); // R8

endmodule

bind rx_byte_queue rxq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .rxValid      (rxValid),
  .rdEn         (rdEn),
  .statusRd     (statusRd),
  .rxIntEn      (rxIntEn),
  .level        (level),
  .overrun      (overrun),
  .dataAvailIrq (dataAvailIrq),
  .timeoutIrq   (timeoutIrq)
);

// File: tb/sim_rx_byte_queue.sv
`timescale 1ns/1ps
module sim_rx_byte_queue;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxValid = 1'b0;
  logic [7:0] rxData = '0;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;
  logic       statusRd = 1'b0;
  logic [1:0] trigSel = 2'd0;
  logic       rxIntEn = 1'b1;
  logic       charTick = 1'b0;
  logic [4:0] level;
  logic       overrun, dataAvailIrq, timeoutIrq;

  int total = 0;
  int bad = 0;

  // reference model state
  logic [7:0] mq[$];
  bit         mOvr = 0;
  int         mIdle = 0;
  logic [7:0] nextByte = 8'h10;

  always #2 clk = ~clk;

  rx_byte_queue u0 (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .rdEn(rdEn),
    .rdData(rdData), .statusRd(statusRd), .trigSel(trigSel), .rxIntEn(rxIntEn),
    .charTick(charTick), .level(level), .overrun(overrun),
    .dataAvailIrq(dataAvailIrq), .timeoutIrq(timeoutIrq)
  );

  function automatic int trigOf(input logic [1:0] s);
    case (s)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic expectEq(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // compare every output against the model (mid low phase)
  task automatic compareAll();
    int lv;
    lv = mq.size();
    expectEq("R1", "level", int'(level), lv);
    if (lv > 0) expectEq("R1", "rdData", int'(rdData), int'(mq[0]));
    expectEq("R2", "dataAvailIrq", int'(dataAvailIrq), int'(rxIntEn && lv >= trigOf(trigSel)));
    expectEq("R5", "timeoutIrq", int'(timeoutIrq), int'(rxIntEn && lv > 0 && mIdle >= 4));
    expectEq("R4", "overrun", int'(overrun), int'(mOvr));
  endtask

  // one clock: drive, check, advance model across the edge
  task automatic cyc(input bit v, input bit rd, input bit sr, input bit tk);
    bit drop, push, pop;
    rxValid = v; rxData = nextByte; rdEn = rd; statusRd = sr; charTick = tk;
    #1;
    compareAll();
    drop = v && (mq.size() == 16);
    push = v && !drop;
    pop  = rd && (mq.size() > 0);
    @(posedge clk);
    #0.5;
    if (pop) void'(mq.pop_front());
    if (push) begin
      mq.push_back(nextByte);
    end
    if (v) nextByte = nextByte + 8'd7;
    if (drop) mOvr = 1;
    else if (sr) mOvr = 0;
    if (push || pop || (mq.size() == 0 && !push) ) mIdle = 0;
    else if (tk && mIdle < 4) mIdle++;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(0, 0, 0, 1);
      cyc(0, 0, 0, 0);
    end
  endtask

  initial begin
    #(4 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // reset
    repeat (3) @(negedge clk);
    expectEq("R9", "level in reset", int'(level), 0);
    expectEq("R9", "overrun in reset", int'(overrun), 0);
    expectEq("R9", "timeoutIrq in reset", int'(timeoutIrq), 0);
    expectEq("R9", "dataAvailIrq in reset", int'(dataAvailIrq), 0);
    rstN = 1'b1;
    idle(2);

    // single byte with threshold 1
    trigSel = 2'd0;
    cyc(1, 0, 0, 0);
    expectEq("R2", "irq at 1 byte", int'(dataAvailIrq), 1);
    cyc(0, 1, 0, 0);
    expectEq("R2", "irq after drain", int'(dataAvailIrq), 0);

    // threshold 4 boundary
    trigSel = 2'd1;
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0);
    expectEq("R2", "below 4", int'(dataAvailIrq), 0);
    cyc(1, 0, 0, 0);
    expectEq("R2", "at 4", int'(dataAvailIrq), 1);
    cyc(0, 1, 0, 0);
    expectEq("R2", "back to 3", int'(dataAvailIrq), 0);
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0);

    // threshold 14, fill to capacity, overflow
    trigSel = 2'd3;
    for (int i = 0; i < 13; i++) cyc(1, 0, 0, 0);
    expectEq("R2", "13 below 14", int'(dataAvailIrq), 0);
    cyc(1, 0, 0, 0);
    expectEq("R2", "reached 14", int'(dataAvailIrq), 1);
    cyc(1, 0, 0, 0);
    cyc(1, 0, 0, 0);
    expectEq("R1", "full level", int'(level), 16);
    cyc(1, 0, 0, 0);
    expectEq("R3", "level stays 16", int'(level), 16);
    expectEq("R4", "overrun set", int'(overrun), 1);
    idle(2);
    expectEq("R4", "overrun sticky", int'(overrun), 1);
    cyc(0, 0, 1, 0);
    expectEq("R4", "overrun cleared", int'(overrun), 0);
    cyc(1, 1, 0, 0);
    expectEq("R3", "drop with read", int'(level), 15);
    expectEq("R4", "overrun from drop+read", int'(overrun), 1);
    cyc(1, 0, 0, 0);
    cyc(1, 0, 1, 0);
    expectEq("R4", "set wins over clear", int'(overrun), 1);
    cyc(0, 0, 1, 0);

    // saturated idle count while full, then a discarded byte
    ticks(4);
    expectEq("R5", "timeout while full", int'(timeoutIrq), 1);
    cyc(1, 0, 0, 0);
    expectEq("R6", "drop keeps timeout", int'(timeoutIrq), 1);
    cyc(0, 0, 1, 0);

    // drain everything, check order, read when empty
    while (mq.size() > 0) cyc(0, 1, 0, 0);
    cyc(0, 1, 0, 0);
    expectEq("R7", "read on empty", int'(level), 0);
    ticks(5);
    expectEq("R7", "no timeout when empty", int'(timeoutIrq), 0);

    // leftover bytes below threshold 8
    trigSel = 2'd2;
    for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0);
    ticks(3);
    expectEq("R5", "three ticks only", int'(timeoutIrq), 0);
    ticks(1);
    expectEq("R5", "four ticks", int'(timeoutIrq), 1);
    cyc(0, 1, 0, 0);
    expectEq("R6", "read clears timeout", int'(timeoutIrq), 0);
    ticks(3);
    cyc(1, 0, 0, 0);
    ticks(3);
    expectEq("R6", "write restarted count", int'(timeoutIrq), 0);
    ticks(1);
    expectEq("R5", "timeout after restart", int'(timeoutIrq), 1);

    // masking
    rxIntEn = 1'b0;
    cyc(0, 1, 0, 0);
    ticks(4);
    expectEq("R8", "masked timeout", int'(timeoutIrq), 0);
    rxIntEn = 1'b1;
    trigSel = 2'd0;
    #0.5;
    expectEq("R8", "unmasked timeout", int'(timeoutIrq), 1);
    expectEq("R8", "unmasked data irq", int'(dataAvailIrq), 1);
    while (mq.size() > 0) cyc(0, 1, 0, 0);
    idle(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule